// File: doc/BRIEF.md
# Self-Modifying Code Detector

This block keeps the instruction stream coherent when a program writes into its own code. It watches two hazards. First, every store physical address is compared against a table of code pages that the decoded-instruction cache currently holds. When a store hits a page marked "in use", the block requests a pipeline flush. Second, every instruction fetch address is compared against the stores that have not yet reached memory. A hit on a speculative store in the store buffer requests a refetch. A hit on a committed store in the write-combining buffer requests a flush.

The code-page table, the store buffer and the write-combining buffer are modelled here as simple register arrays. The surrounding pipeline maintains them through slot-indexed update ports:

- fill and invalidate for the code-page table;
- allocate and release for the store buffer;
- allocate and drain for the write-combining buffer.

Requests are registered. Each lasts one cycle per triggering event.

Top module: `smc_guard`

## Requirements
- R1: After reset both `flushReq` and `refetchReq` are 0. In any cycle that has neither a store lookup nor a fetch lookup, both outputs are 0 in the following cycle.
- R2: A store lookup raises `flushReq` one cycle later when some page-table entry is in use and its page tag equals the store address bits [ADDR_W-1:PAGE_BITS] (4 KiB pages by default). The low PAGE_BITS address bits are ignored.
- R3: A fill writes the page tag into its slot and marks the slot in use. An invalidate clears the in-use mark, after which stores to that page no longer flush. A fill and an invalidate of the same slot in the same cycle leave the slot in use with the new tag.
- R4: A fetch lookup raises `refetchReq` one cycle later when a valid store-buffer entry holds the same line, meaning address bits [ADDR_W-1:LINE_BITS] (32-byte lines by default).
- R5: A fetch lookup raises `flushReq` one cycle later when a valid write-combining entry holds the same line.
- R6: Buffer matching works at line granularity. Fetches to a different line never hit, and the low LINE_BITS bits are ignored.
- R7: `flushReq` and `refetchReq` are never both 1. Whenever a flush condition exists, which covers a code-page hit from a store in the same cycle, the refetch is suppressed.
- R8: Releasing a store-buffer slot, or draining a write-combining slot, removes that entry from matching. An allocate and a release or drain of the same slot in the same cycle leave the slot valid with the new address.
- R9: Lookups see the table and buffer contents from before the clock edge. An update made in the same cycle affects lookups only from the next cycle on.
- R10: Each request is high for exactly the one cycle after the cycle of its lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stAddrVld | input | 1 | Store address lookup valid |
| stAddr | input | ADDR_W | Store physical address |
| fetchVld | input | 1 | Fetch address lookup valid |
| fetchAddr | input | ADDR_W | Fetch physical address |
| fillVld | input | 1 | Code-page fill into slot `fillIdx` |
| fillIdx | input | log2(PT_DEPTH) | Page-table slot to fill |
| fillPage | input | ADDR_W-PAGE_BITS | Page tag written by the fill |
| invVld | input | 1 | Clear in-use mark of slot `invIdx` |
| invIdx | input | log2(PT_DEPTH) | Page-table slot to invalidate |
| sbAllocVld | input | 1 | Store-buffer allocate |
| sbAllocIdx | input | log2(SB_DEPTH) | Store-buffer slot to allocate |
| sbAllocAddr | input | ADDR_W | Address of the speculative store |
| sbRelVld | input | 1 | Store-buffer release |
| sbRelIdx | input | log2(SB_DEPTH) | Store-buffer slot to release |
| wcbAllocVld | input | 1 | Write-combining allocate |
| wcbAllocIdx | input | log2(WCB_DEPTH) | Write-combining slot to allocate |
| wcbAllocAddr | input | ADDR_W | Address of the committed store |
| wcbDrainVld | input | 1 | Write-combining drain |
| wcbDrainIdx | input | log2(WCB_DEPTH) | Write-combining slot to drain |
| flushReq | output | 1 | Pipeline flush request |
| refetchReq | output | 1 | Refetch request |

## Verification
The properties assume that the pipeline keeps inputs quiet while reset is asserted. They also assume that a request is traced only to a lookup made in the previous cycle, so no other source may be treated as the cause of `flushReq` or `refetchReq`. Slot indices are always in range, since the index widths come from the depths. The stimulus holds every valid low during reset. It drives updates and lookups at the falling edge and samples the outputs at the following falling edge, one registered cycle later. It sweeps store pages across a fully populated page table twice, once before and once after invalidating every odd slot. It also sweeps fetch lines around each buffer entry, and it places updates and lookups in the same cycle to observe the ordering rules.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef struct packed {
    logic ptFill;
    logic ptInv;
    logic sbAlloc;
    logic sbRel;
    logic wcbAlloc;
    logic wcbDrain;
    logic stLook;
    logic fetchLook;
  } smc_strobe_t;
endpackage

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 5,
  parameter int PT_DEPTH  = 128,
  parameter int SB_DEPTH  = 8,
  parameter int WCB_DEPTH = 4,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS,
  localparam int LINE_W   = ADDR_W - LINE_BITS,
  localparam int PT_IDX_W = $clog2(PT_DEPTH),
  localparam int SB_IDX_W = $clog2(SB_DEPTH),
  localparam int WC_IDX_W = $clog2(WCB_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  smc_strobe_t         strb,
  input  logic [PT_IDX_W-1:0] fillIdx,
  input  logic [PAGE_W-1:0]   fillPage,
  input  logic [PT_IDX_W-1:0] invIdx,
  input  logic [SB_IDX_W-1:0] sbAllocIdx,
  input  logic [ADDR_W-1:0]   sbAllocAddr,
  input  logic [SB_IDX_W-1:0] sbRelIdx,
  input  logic [WC_IDX_W-1:0] wcbAllocIdx,
  input  logic [ADDR_W-1:0]   wcbAllocAddr,
  input  logic [WC_IDX_W-1:0] wcbDrainIdx,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [ADDR_W-1:0]   fetchAddr,
  output logic                codeHit,
  output logic                sbHit,
  output logic                wcbHit
);
  logic [PAGE_W-1:0] stPage;
  logic [LINE_W-1:0] fetchLine;
  logic [PT_DEPTH-1:0]  ptHitVec;
  logic [SB_DEPTH-1:0]  sbHitVec;
  logic [WCB_DEPTH-1:0] wcHitVec;
  logic unusedLowBits;

  assign stPage    = stAddr[ADDR_W-1:PAGE_BITS];
  assign fetchLine = fetchAddr[ADDR_W-1:LINE_BITS];
  assign unusedLowBits = ^{stAddr[PAGE_BITS-1:0], fetchAddr[LINE_BITS-1:0],
                           sbAllocAddr[LINE_BITS-1:0], wcbAllocAddr[LINE_BITS-1:0]};

  // Code-page table: fill outranks invalidate on the same slot.
  for (genvar i = 0; i < PT_DEPTH; i++) begin : g_pt
    logic              inUse;
    logic [PAGE_W-1:0] tag;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inUse <= 1'b0;
        tag   <= '0;
      end else if (strb.ptFill && fillIdx == PT_IDX_W'(i)) begin
        inUse <= 1'b1;
        tag   <= fillPage;
      end else if (strb.ptInv && invIdx == PT_IDX_W'(i)) begin
        inUse <= 1'b0;
      end
    end
    assign ptHitVec[i] = inUse && (tag == stPage);
  end

  // Speculative store buffer: allocate outranks release.
  for (genvar i = 0; i < SB_DEPTH; i++) begin : g_sb
    logic              vld;
    logic [LINE_W-1:0] line;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld  <= 1'b0;
        line <= '0;
      end else if (strb.sbAlloc && sbAllocIdx == SB_IDX_W'(i)) begin
        vld  <= 1'b1;
        line <= sbAllocAddr[ADDR_W-1:LINE_BITS];
      end else if (strb.sbRel && sbRelIdx == SB_IDX_W'(i)) begin
        vld  <= 1'b0;
      end
    end
    assign sbHitVec[i] = vld && (line == fetchLine);
  end

  // Committed write-combining buffer: allocate outranks drain.
  for (genvar i = 0; i < WCB_DEPTH; i++) begin : g_wc
    logic              vld;
    logic [LINE_W-1:0] line;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld  <= 1'b0;
        line <= '0;
      end else if (strb.wcbAlloc && wcbAllocIdx == WC_IDX_W'(i)) begin
        vld  <= 1'b1;
        line <= wcbAllocAddr[ADDR_W-1:LINE_BITS];
      end else if (strb.wcbDrain && wcbDrainIdx == WC_IDX_W'(i)) begin
        vld  <= 1'b0;
      end
    end
    assign wcHitVec[i] = vld && (line == fetchLine);
  end

  assign codeHit = strb.stLook    && (|ptHitVec);
  assign sbHit   = strb.fetchLook && (|sbHitVec);
  assign wcbHit  = strb.fetchLook && (|wcHitVec);
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stAddrVld,
  input  logic        fetchVld,
  input  logic        fillVld,
  input  logic        invVld,
  input  logic        sbAllocVld,
  input  logic        sbRelVld,
  input  logic        wcbAllocVld,
  input  logic        wcbDrainVld,
  input  logic        codeHit,
  input  logic        sbHit,
  input  logic        wcbHit,
  output smc_strobe_t strb,
  output logic        flushReq,
  output logic        refetchReq
);
  logic flushCond;

  always_comb begin
    strb.ptFill    = fillVld;
    strb.ptInv     = invVld;
    strb.sbAlloc   = sbAllocVld;
    strb.sbRel     = sbRelVld;
    strb.wcbAlloc  = wcbAllocVld;
    strb.wcbDrain  = wcbDrainVld;
    strb.stLook    = stAddrVld;
    strb.fetchLook = fetchVld;
  end

  // A flush discards everything a refetch would, so it takes precedence.
  assign flushCond = codeHit || wcbHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flushReq   <= 1'b0;
      refetchReq <= 1'b0;
    end else begin
      flushReq   <= flushCond;
      refetchReq <= sbHit && !flushCond;
    end
  end
endmodule

// File: rtl/smc_guard.sv
module smc_guard
  import smc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 5,
  parameter int PT_DEPTH  = 128,
  parameter int SB_DEPTH  = 8,
  parameter int WCB_DEPTH = 4,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS,
  localparam int PT_IDX_W = $clog2(PT_DEPTH),
  localparam int SB_IDX_W = $clog2(SB_DEPTH),
  localparam int WC_IDX_W = $clog2(WCB_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stAddrVld,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic                fetchVld,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic                fillVld,
  input  logic [PT_IDX_W-1:0] fillIdx,
  input  logic [PAGE_W-1:0]   fillPage,
  input  logic                invVld,
  input  logic [PT_IDX_W-1:0] invIdx,
  input  logic                sbAllocVld,
  input  logic [SB_IDX_W-1:0] sbAllocIdx,
  input  logic [ADDR_W-1:0]   sbAllocAddr,
  input  logic                sbRelVld,
  input  logic [SB_IDX_W-1:0] sbRelIdx,
  input  logic                wcbAllocVld,
  input  logic [WC_IDX_W-1:0] wcbAllocIdx,
  input  logic [ADDR_W-1:0]   wcbAllocAddr,
  input  logic                wcbDrainVld,
  input  logic [WC_IDX_W-1:0] wcbDrainIdx,
  output logic                flushReq,
  output logic                refetchReq
);
  smc_strobe_t strb;
  logic codeHit, sbHit, wcbHit;

  smc_ctrl u_ctrl (
    .clk, .rst_n, .stAddrVld, .fetchVld, .fillVld, .invVld,
    .sbAllocVld, .sbRelVld, .wcbAllocVld, .wcbDrainVld,
    .codeHit, .sbHit, .wcbHit, .strb, .flushReq, .refetchReq
  );

  smc_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS),
    .PT_DEPTH(PT_DEPTH), .SB_DEPTH(SB_DEPTH), .WCB_DEPTH(WCB_DEPTH)
  ) u_dp (
    .clk, .rst_n, .strb, .fillIdx, .fillPage, .invIdx,
    .sbAllocIdx, .sbAllocAddr, .sbRelIdx,
    .wcbAllocIdx, .wcbAllocAddr, .wcbDrainIdx,
    .stAddr, .fetchAddr, .codeHit, .sbHit, .wcbHit
  );
endmodule

// File: rtl/smc_guard_chk.sv
module smc_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic stAddrVld,
  input logic fetchVld,
  input logic flushReq,
  input logic refetchReq
);
  // R7: the two recovery requests never coincide
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flushReq && refetchReq));

  // R1 / R10: no lookup means no request in the next cycle
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stAddrVld && !fetchVld) |=> (!flushReq && !refetchReq));

  // R4: a refetch can only follow a fetch lookup
  p_refetch_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchVld |=> !refetchReq);

  // R2: a lone store lookup can only cause a flush
  p_store_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stAddrVld && !fetchVld) |=> !refetchReq);
endmodule

bind smc_guard smc_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stAddrVld(stAddrVld), .fetchVld(fetchVld),
  .flushReq(flushReq), .refetchReq(refetchReq)
);

// File: tb/smc_guard_bench.sv
module smc_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, PB = 12, LB = 5, PTD = 128, SBD = 8, WCD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stAddrVld = 0, fetchVld = 0, fillVld = 0, invVld = 0;
  logic sbAllocVld = 0, sbRelVld = 0, wcbAllocVld = 0, wcbDrainVld = 0;
  logic [AW-1:0] stAddr = '0, fetchAddr = '0, sbAllocAddr = '0, wcbAllocAddr = '0;
  logic [6:0] fillIdx = '0, invIdx = '0;
  logic [AW-PB-1:0] fillPage = '0;
  logic [2:0] sbAllocIdx = '0, sbRelIdx = '0;
  logic [1:0] wcbAllocIdx = '0, wcbDrainIdx = '0;
  logic flushReq, refetchReq;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [AW-PB-1:0] mTag [PTD];
  bit               mUse [PTD];
  logic [AW-LB-1:0] mSb  [SBD];
  bit               mSbV [SBD];
  logic [AW-LB-1:0] mWc  [WCD];
  bit               mWcV [WCD];

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_guard u_smc_guard (
    .clk, .rst_n, .stAddrVld, .stAddr, .fetchVld, .fetchAddr,
    .fillVld, .fillIdx, .fillPage, .invVld, .invIdx,
    .sbAllocVld, .sbAllocIdx, .sbAllocAddr, .sbRelVld, .sbRelIdx,
    .wcbAllocVld, .wcbAllocIdx, .wcbAllocAddr, .wcbDrainVld, .wcbDrainIdx,
    .flushReq, .refetchReq
  );

  task automatic check(string req, logic expF, logic expR);
    total++;
    if (flushReq !== expF || refetchReq !== expR) begin
      bad++;
      $display("FAIL %s: flush=%b refetch=%b expected flush=%b refetch=%b",
               req, flushReq, refetchReq, expF, expR);
    end
  endtask

  // Drives the inputs already set for one edge, checks at the next falling edge,
  // then updates the model (lookups see pre-edge contents, R9).
  task automatic step(string req);
    bit cHit = 0, sHit = 0, wHit = 0;
    logic expF, expR;
    for (int i = 0; i < PTD; i++)
      if (stAddrVld && mUse[i] && mTag[i] == stAddr[AW-1:PB]) cHit = 1;
    for (int i = 0; i < SBD; i++)
      if (fetchVld && mSbV[i] && mSb[i] == fetchAddr[AW-1:LB]) sHit = 1;
    for (int i = 0; i < WCD; i++)
      if (fetchVld && mWcV[i] && mWc[i] == fetchAddr[AW-1:LB]) wHit = 1;
    expF = cHit || wHit;
    expR = sHit && !expF;
    if (invVld) mUse[invIdx] = 0;
    if (fillVld) begin mUse[fillIdx] = 1; mTag[fillIdx] = fillPage; end
    if (sbRelVld) mSbV[sbRelIdx] = 0;
    if (sbAllocVld) begin mSbV[sbAllocIdx] = 1; mSb[sbAllocIdx] = sbAllocAddr[AW-1:LB]; end
    if (wcbDrainVld) mWcV[wcbDrainIdx] = 0;
    if (wcbAllocVld) begin mWcV[wcbAllocIdx] = 1; mWc[wcbAllocIdx] = wcbAllocAddr[AW-1:LB]; end
    @(posedge clk);
    @(negedge clk);
    stAddrVld = 0; fetchVld = 0; fillVld = 0; invVld = 0;
    sbAllocVld = 0; sbRelVld = 0; wcbAllocVld = 0; wcbDrainVld = 0;
    check(req, expF, expR);
  endtask

  task automatic doStore(string req, int page, int off);
    stAddrVld = 1; stAddr = {AW'(page)} << PB | AW'(off); step(req);
  endtask

  task automatic doFetch(string req, logic [AW-1:0] a);
    fetchVld = 1; fetchAddr = a; step(req);
  endtask

  initial begin
    for (int i = 0; i < PTD; i++) begin mUse[i] = 0; mTag[i] = '0; end
    for (int i = 0; i < SBD; i++) begin mSbV[i] = 0; mSb[i] = '0; end
    for (int i = 0; i < WCD; i++) begin mWcV[i] = 0; mWc[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", 1'b0, 1'b0);

    // R3: fill every slot with a spread of pages, then sweep stores (R2)
    for (int i = 0; i < PTD; i++) begin
      fillVld = 1; fillIdx = 7'(i); fillPage = 20'(i*3 + 1); step("R3 fill");
    end
    for (int p = 0; p < 390; p++) doStore("R2 sweep", p, (p*37) % 4096);
    for (int i = 1; i < PTD; i += 2) begin
      invVld = 1; invIdx = 7'(i); step("R3 inv");
    end
    for (int p = 0; p < 390; p++) doStore("R3 sweep after inv", p, 4095 - p);
    // R3: fill and invalidate same slot in one cycle keeps it in use
    fillVld = 1; invVld = 1; fillIdx = 7'd5; invIdx = 7'd5; fillPage = 20'hABCDE;
    step("R3 fill+inv");
    doStore("R3 fill wins", 20'hABCDE, 0);
    // R9: fill and store in the same cycle; the store sees the old contents
    fillVld = 1; fillIdx = 7'd7; fillPage = 20'h55555;
    stAddrVld = 1; stAddr = 32'h55555_123; step("R9 same-cycle fill");
    doStore("R9 next cycle", 20'h55555, 12'h123);
    // R10: one cycle only
    step("R10 pulse width");

    // Store buffer (R4, R6)
    for (int s = 0; s < SBD; s++) begin
      sbAllocVld = 1; sbAllocIdx = 3'(s); sbAllocAddr = 32'h4000_0000 + s*64 + 3; step("R4 alloc");
    end
    for (int l = -2; l < 2*SBD + 2; l++)
      for (int b = 0; b < 32; b += 13)
        doFetch("R4/R6 sb sweep", 32'h4000_0000 + l*32 + b);
    // R8 release, and alloc outranks release
    sbRelVld = 1; sbRelIdx = 3'd2; step("R8 release");
    doFetch("R8 released", 32'h4000_0080);
    sbRelVld = 1; sbAllocVld = 1; sbRelIdx = 3'd3; sbAllocIdx = 3'd3;
    sbAllocAddr = 32'h4000_0100; step("R8 alloc+rel");
    doFetch("R8 alloc wins", 32'h4000_011F);

    // Write-combining buffer (R5) and priority (R7)
    for (int w = 0; w < WCD; w++) begin
      wcbAllocVld = 1; wcbAllocIdx = 2'(w); wcbAllocAddr = 32'h6000_0000 + w*32; step("R5 alloc");
    end
    for (int l = -1; l < WCD + 1; l++) doFetch("R5/R6 wcb sweep", 32'h6000_0000 + l*32 + 7);
    wcbAllocVld = 1; wcbAllocIdx = 2'd0; wcbAllocAddr = 32'h4000_0000; step("R7 overlap alloc");
    doFetch("R7 wcb over sb", 32'h4000_0004);
    stAddrVld = 1; stAddr = 32'h0000_1000; fetchVld = 1; fetchAddr = 32'h4000_0040;
    step("R7 store flush over refetch");
    wcbDrainVld = 1; wcbDrainIdx = 2'd0; step("R8 drain");
    doFetch("R8 drained", 32'h4000_0004);
    wcbDrainVld = 1; wcbAllocVld = 1; wcbDrainIdx = 2'd1; wcbAllocIdx = 2'd1;
    wcbAllocAddr = 32'h7000_0000; step("R8 alloc+drain");
    doFetch("R8 wcb alloc wins", 32'h7000_0010);
    step("R1 idle end");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule